// File: doc/BRIEF.md
# Multicycle Controller-Datapath Processor

This block is a compact non-pipelined processor built as a state-machine controller steering a 16-bit datapath. It holds a program counter, an instruction register, a sixteen-entry register file and one shared ALU. It reaches a single unified memory, holding both code and data, through one address bus, a write-data bus, a read-data bus and separate read and write strobes. The memory is assumed to return read data one clock after the read strobe.

Every instruction passes through a fetch state, a read-capture state, a decode state and one execute state. A memory load adds one further wait state. The `run_i` input gates the whole machine. With `run_i` held high the processor runs without a halt instruction. With it low, every state element holds and no memory strobe is raised, so a host can inspect the machine. The inspection path gives the program counter and any register selected by `dbg_sel_i`.

Instruction word: opcode in bits 15:12, `rn` in 11:8, `rm` in 7:4, and an 8-bit field in 7:0. That field serves as the direct address, the immediate value or the jump target, depending on the opcode.

Top module: `fsmd_cpu`

## Requirements
- R1: While `rst_ni` is low, PC and all registers read 0 and `mem_we_o` is 0. In the first cycle after release with `run_i` high, `mem_re_o`=1 and `mem_addr_o`=0.
- R2: In fetch, `mem_addr_o` equals PC with `mem_re_o`=1. The returned word becomes the instruction and PC advances by exactly 1.
- R3: Opcode 0000 writes RF[rn] with the memory word at the zero-extended 8-bit field.
- R4: Opcode 0001 writes RF[rn] to memory at the zero-extended 8-bit field.
- R5: Opcode 0010 writes RF[rm] to memory at the address held in RF[rn].
- R6: Opcode 0011 writes the 8-bit field, zero-extended, into RF[rn].
- R7: Opcode 0100 sets RF[rn]=RF[rn]+RF[rm] and opcode 0101 sets RF[rn]=RF[rn]-RF[rm], both modulo 2^16.
- R8: Opcode 0110 loads PC with the zero-extended 8-bit field when RF[rn] is zero. Otherwise PC keeps the already incremented value.
- R9: Opcodes 0111 to 1111 change no register and no memory word, and execution continues at the next word.
- R10: A load takes 5 cycles and every other instruction takes 4. Read and write strobes are never high together, and each store raises `mem_we_o` for exactly one cycle.
- R11: `dbg_reg_o` shows register `dbg_sel_i` and `dbg_pc_o` shows PC, combinationally.
- R12: While `run_i` is low, PC, registers, instruction and state hold, and both memory strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Advance enable for the whole machine |
| mem_addr_o | output | 16 | Memory word address |
| mem_rdata_i | input | 16 | Read data, valid one cycle after the read strobe |
| mem_wdata_o | output | 16 | Write data |
| mem_re_o | output | 1 | Read strobe |
| mem_we_o | output | 1 | Write strobe |
| dbg_sel_i | input | 4 | Register index for inspection |
| dbg_pc_o | output | 16 | Current program counter |
| dbg_reg_o | output | 16 | Contents of the selected register |

## Verification
The bench builds the block with its default 16-bit data width and sixteen registers, so every instruction field is exercised at full size. Its memory model keeps 256 words and aliases higher addresses onto them. This puts random direct, indirect and jump addresses on live data, and lets programs overwrite their own code. Random programs are compared against an instruction-level model that also predicts the exact cycle count, so both the stall after a load and the taken and not-taken jump paths are checked. A directed loop adds hand-computed results.

// File: rtl/fsmd_pkg.sv
package fsmd_pkg;

  localparam logic [3:0] OPC_LD  = 4'b0000;
  localparam logic [3:0] OPC_ST  = 4'b0001;
  localparam logic [3:0] OPC_STI = 4'b0010;
  localparam logic [3:0] OPC_IMM = 4'b0011;
  localparam logic [3:0] OPC_ADD = 4'b0100;
  localparam logic [3:0] OPC_SUB = 4'b0101;
  localparam logic [3:0] OPC_JZ  = 4'b0110;

  typedef enum logic [3:0] {
    S_FETCH, S_LOADIR, S_DECODE,
    S_LD, S_LD_W, S_ST, S_STI, S_IMM, S_ADD, S_SUB, S_JZ, S_NOP
  } state_e;

  typedef enum logic [1:0] {
    WSRC_ALU = 2'b00, WSRC_MEM = 2'b01, WSRC_IMM = 2'b10
  } wsrc_e;

  typedef enum logic [1:0] {
    ALU_ADD = 2'b00, ALU_SUB = 2'b01
  } aluop_e;

  typedef enum logic [1:0] {
    ASRC_PC = 2'b00, ASRC_DIR = 2'b01, ASRC_REG = 2'b10
  } asrc_e;

  typedef struct packed {
    logic   ir_ld;
    logic   pc_inc;
    logic   jmp;
    logic   rf_we;
    wsrc_e  wsrc;
    logic   r1_en;
    logic   r2_en;
    aluop_e alu_op;
    asrc_e  asrc;
    logic   wd_r2;
    logic   mem_re;
    logic   mem_we;
  } ctrl_t;

endpackage

// File: rtl/fsmd_regfile.sv
module fsmd_regfile #(
  parameter int unsigned DW   = 16,
  parameter int unsigned NREG = 16,
  localparam int unsigned RA_W = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [RA_W-1:0] r1_addr_i,
  input  logic            r1_en_i,
  output logic [DW-1:0]   r1_data_o,
  input  logic [RA_W-1:0] r2_addr_i,
  input  logic            r2_en_i,
  output logic [DW-1:0]   r2_data_o,
  input  logic [RA_W-1:0] w_addr_i,
  input  logic            w_en_i,
  input  logic [DW-1:0]   w_data_i,
  input  logic [RA_W-1:0] dbg_addr_i,
  output logic [DW-1:0]   dbg_data_o
);

  logic [DW-1:0] regs_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (w_en_i) begin
      regs_q[w_addr_i] <= w_data_i;
    end
  end

  // disabled read ports drive zero so the ALU sees a neutral operand
  assign r1_data_o  = r1_en_i ? regs_q[r1_addr_i] : '0;
  assign r2_data_o  = r2_en_i ? regs_q[r2_addr_i] : '0;
  assign dbg_data_o = regs_q[dbg_addr_i];

endmodule

// File: rtl/fsmd_alu.sv
module fsmd_alu #(
  parameter int unsigned DW = 16
) (
  input  fsmd_pkg::aluop_e op_i,
  input  logic [DW-1:0]    a_i,
  input  logic [DW-1:0]    b_i,
  output logic [DW-1:0]    y_o,
  output logic             zero_o
);
  import fsmd_pkg::*;

  always_comb begin
    unique case (op_i)
      ALU_ADD: y_o = a_i + b_i;
      ALU_SUB: y_o = a_i - b_i;
      default: y_o = a_i;
    endcase
  end

  assign zero_o = (y_o == '0);

endmodule

// File: rtl/fsmd_ctrl.sv
module fsmd_ctrl (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [3:0]       opcode_i,
  output fsmd_pkg::state_e state_o,
  output fsmd_pkg::ctrl_t  ctrl_o
);
  import fsmd_pkg::*;

  state_e state_q, state_d;
  ctrl_t  ctrl_raw;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_FETCH:  state_d = S_LOADIR;
      S_LOADIR: state_d = S_DECODE;
      S_DECODE: begin
        unique case (opcode_i)
          OPC_LD:  state_d = S_LD;
          OPC_ST:  state_d = S_ST;
          OPC_STI: state_d = S_STI;
          OPC_IMM: state_d = S_IMM;
          OPC_ADD: state_d = S_ADD;
          OPC_SUB: state_d = S_SUB;
          OPC_JZ:  state_d = S_JZ;
          default: state_d = S_NOP;
        endcase
      end
      S_LD:    state_d = S_LD_W;
      default: state_d = S_FETCH;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    state_q <= S_FETCH;
    else if (run_i) state_q <= state_d;
  end

  always_comb begin
    ctrl_raw        = '0;
    ctrl_raw.wsrc   = WSRC_ALU;
    ctrl_raw.alu_op = ALU_ADD;
    ctrl_raw.asrc   = ASRC_PC;
    unique case (state_q)
      S_FETCH:  ctrl_raw.mem_re = 1'b1;
      S_LOADIR: begin ctrl_raw.ir_ld = 1'b1; ctrl_raw.pc_inc = 1'b1; end
      S_LD:     begin ctrl_raw.mem_re = 1'b1; ctrl_raw.asrc = ASRC_DIR; end
      S_LD_W:   begin ctrl_raw.rf_we = 1'b1; ctrl_raw.wsrc = WSRC_MEM; end
      S_ST: begin
        ctrl_raw.r1_en = 1'b1; ctrl_raw.asrc = ASRC_DIR; ctrl_raw.mem_we = 1'b1;
      end
      S_STI: begin
        ctrl_raw.r1_en = 1'b1; ctrl_raw.r2_en = 1'b1; ctrl_raw.asrc = ASRC_REG;
        ctrl_raw.wd_r2 = 1'b1; ctrl_raw.mem_we = 1'b1;
      end
      S_IMM:    begin ctrl_raw.rf_we = 1'b1; ctrl_raw.wsrc = WSRC_IMM; end
      S_ADD, S_SUB: begin
        ctrl_raw.r1_en  = 1'b1; ctrl_raw.r2_en = 1'b1; ctrl_raw.rf_we = 1'b1;
        ctrl_raw.alu_op = (state_q == S_SUB) ? ALU_SUB : ALU_ADD;
      end
      // rm port off: ALU passes RF[rn] through for the zero test
      S_JZ:     begin ctrl_raw.r1_en = 1'b1; ctrl_raw.jmp = 1'b1; end
      default:  ;
    endcase
  end

  assign state_o = state_q;
  assign ctrl_o  = run_i ? ctrl_raw : '0;

endmodule

// File: rtl/fsmd_cpu.sv
module fsmd_cpu #(
  parameter int unsigned DW   = 16,
  parameter int unsigned NREG = 16,
  localparam int unsigned RA_W = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  output logic [DW-1:0]   mem_addr_o,
  input  logic [DW-1:0]   mem_rdata_i,
  output logic [DW-1:0]   mem_wdata_o,
  output logic            mem_re_o,
  output logic            mem_we_o,
  input  logic [RA_W-1:0] dbg_sel_i,
  output logic [DW-1:0]   dbg_pc_o,
  output logic [DW-1:0]   dbg_reg_o
);
  import fsmd_pkg::*;

  localparam int unsigned FW = 8;

  state_e        state;
  ctrl_t         ctrl;
  logic [DW-1:0] pc_q, ir_q;
  logic [DW-1:0] rd1, rd2, alu_y, rf_wd, field_zx;
  logic          alu_zero;

  assign field_zx = {{(DW-FW){1'b0}}, ir_q[FW-1:0]};

  fsmd_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run_i),
    .opcode_i (ir_q[15:12]),
    .state_o  (state),
    .ctrl_o   (ctrl)
  );

  fsmd_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .r1_addr_i  (ir_q[8 +: RA_W]),
    .r1_en_i    (ctrl.r1_en),
    .r1_data_o  (rd1),
    .r2_addr_i  (ir_q[4 +: RA_W]),
    .r2_en_i    (ctrl.r2_en),
    .r2_data_o  (rd2),
    .w_addr_i   (ir_q[8 +: RA_W]),
    .w_en_i     (ctrl.rf_we),
    .w_data_i   (rf_wd),
    .dbg_addr_i (dbg_sel_i),
    .dbg_data_o (dbg_reg_o)
  );

  fsmd_alu #(.DW(DW)) u_alu (
    .op_i   (ctrl.alu_op),
    .a_i    (rd1),
    .b_i    (rd2),
    .y_o    (alu_y),
    .zero_o (alu_zero)
  );

  always_comb begin
    unique case (ctrl.wsrc)
      WSRC_MEM: rf_wd = mem_rdata_i;
      WSRC_IMM: rf_wd = field_zx;
      default:  rf_wd = alu_y;
    endcase
  end

  always_comb begin
    unique case (ctrl.asrc)
      ASRC_DIR: mem_addr_o = field_zx;
      ASRC_REG: mem_addr_o = rd1;
      default:  mem_addr_o = pc_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0;
      ir_q <= '0;
    end else begin
      if (ctrl.ir_ld) ir_q <= mem_rdata_i;
      if (ctrl.pc_inc)                pc_q <= pc_q + 1'b1;
      else if (ctrl.jmp && alu_zero)  pc_q <= field_zx;
    end
  end

  assign mem_wdata_o = ctrl.wd_r2 ? rd2 : rd1;
  assign mem_re_o    = ctrl.mem_re;
  assign mem_we_o    = ctrl.mem_we;
  assign dbg_pc_o    = pc_q;

endmodule

// File: rtl/fsmd_cpu_chk.sv
module fsmd_cpu_chk #(
  parameter int unsigned DW = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run_i,
  input logic             mem_re_i,
  input logic             mem_we_i,
  input logic [DW-1:0]    mem_addr_i,
  input logic [DW-1:0]    pc_i,
  input logic [DW-1:0]    rd1_i,
  input fsmd_pkg::state_e state_i
);
  import fsmd_pkg::*;

  // R10
  no_rw_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_re_i && mem_we_i));

  // R10
  we_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_i |=> !mem_we_i);

  // R2
  fetch_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == S_FETCH && run_i) |-> (mem_re_i && mem_addr_i == pc_i));

  // R2
  pc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == S_LOADIR && run_i) |=> (pc_i == $past(pc_i) + 1'b1));

  // R8
  jz_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == S_JZ && rd1_i != '0) |=> (pc_i == $past(pc_i)));

  // R3
  ld_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == S_LD_W) |-> $past(mem_re_i));

  // R12
  freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> ($stable(pc_i) && $stable(state_i)));

  // R12
  idle_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> (!mem_re_i && !mem_we_i));

endmodule

bind fsmd_cpu fsmd_cpu_chk #(.DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .run_i      (run_i),
  .mem_re_i   (mem_re_o),
  .mem_we_i   (mem_we_o),
  .mem_addr_i (mem_addr_o),
  .pc_i       (pc_q),
  .rd1_i      (rd1),
  .state_i    (state)
);

// File: tb/fsmd_cpu_tb.sv
module fsmd_cpu_tb;

  localparam int CLK_PERIOD = 10;
  localparam int MW = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic [15:0] mem_addr, mem_rdata, mem_wdata, dbg_pc, dbg_reg;
  logic        mem_re, mem_we;
  logic [3:0]  dbg_sel = '0;

  logic        ld_en = 1'b0;
  logic [7:0]  ld_addr = '0;
  logic [15:0] ld_data = '0;
  logic [15:0] mem [MW];

  int errors = 0, checks = 0;
  int we_total = 0, overlap_total = 0;
  bit done = 0;

  logic [15:0] img [MW];
  logic [15:0] ref_mem [MW];
  logic [15:0] ref_rf [16];
  logic [15:0] ref_pc;
  int          ref_cyc, ref_st;

  always #(CLK_PERIOD/2) clk = ~clk;

  fsmd_cpu u_dut (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run),
    .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata), .mem_wdata_o(mem_wdata),
    .mem_re_o(mem_re), .mem_we_o(mem_we),
    .dbg_sel_i(dbg_sel), .dbg_pc_o(dbg_pc), .dbg_reg_o(dbg_reg)
  );

  always @(posedge clk) begin
    if (ld_en) mem[ld_addr] <= ld_data;
    else begin
      if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
      if (mem_re) mem_rdata <= mem[mem_addr[7:0]];
    end
    if (rst_n && mem_we) we_total <= we_total + 1;
  end

  always @(negedge clk) if (rst_n && mem_re && mem_we) overlap_total <= overlap_total + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference instruction step: returns nothing, updates model state
  task automatic ref_step();
    logic [15:0] ins = ref_mem[ref_pc[7:0]];
    logic [3:0]  rn = ins[11:8], rm = ins[7:4];
    logic [7:0]  lo = ins[7:0];
    ref_pc = ref_pc + 16'd1;
    ref_cyc += 4;
    case (ins[15:12])
      4'h0: begin ref_rf[rn] = ref_mem[lo]; ref_cyc += 1; end
      4'h1: begin ref_mem[lo] = ref_rf[rn]; ref_st++; end
      4'h2: begin ref_mem[ref_rf[rn][7:0]] = ref_rf[rm]; ref_st++; end
      4'h3: ref_rf[rn] = {8'h00, lo};
      4'h4: ref_rf[rn] = ref_rf[rn] + ref_rf[rm];
      4'h5: ref_rf[rn] = ref_rf[rn] - ref_rf[rm];
      4'h6: if (ref_rf[rn] == 16'h0) ref_pc = {8'h00, lo};
      default: ;
    endcase
  endtask

  task automatic read_reg(input int r, output logic [15:0] v);
    dbg_sel = r[3:0];
    #1 v = dbg_reg;
  endtask

  task automatic run_prog(input int n, input string tag);
    int we0, ov0, nz;
    logic [15:0] v, pc_hold;
    @(negedge clk);
    rst_n = 1'b0; run = 1'b0;
    for (int i = 0; i < MW; i++) begin
      ld_en = 1'b1; ld_addr = i[7:0]; ld_data = img[i];
      @(negedge clk);
    end
    ld_en = 1'b0;
    // R1 reset state
    chk({"R1 pc in reset ", tag}, dbg_pc, 16'h0);
    chk({"R1 no write in reset ", tag}, mem_we, 1'b0);
    nz = 0;
    for (int r = 0; r < 16; r++) begin read_reg(r, v); if (v != 0) nz++; end
    chk({"R1 regs zero in reset ", tag}, nz, 0);
    for (int i = 0; i < MW; i++) ref_mem[i] = img[i];
    for (int r = 0; r < 16; r++) ref_rf[r] = '0;
    ref_pc = '0; ref_cyc = 0; ref_st = 0;
    for (int k = 0; k < n; k++) ref_step();
    we0 = we_total; ov0 = overlap_total;
    @(negedge clk);
    rst_n = 1'b1; run = 1'b1;
    #1;
    chk({"R1 first fetch ", tag}, {mem_re, mem_addr}, {1'b1, 16'h0});
    repeat (ref_cyc) @(posedge clk);
    @(negedge clk);
    // R10: cycle count lands exactly on the next fetch
    chk({"R10 fetch at predicted cycle ", tag}, {mem_re, mem_addr}, {1'b1, ref_pc});
    run = 1'b0;
    chk({"R2 pc ", tag}, dbg_pc, ref_pc);
    for (int r = 0; r < 16; r++) begin
      read_reg(r, v);
      chk($sformatf("R11 reg %0d %s", r, tag), v, ref_rf[r]);
    end
    nz = 0;
    for (int i = 0; i < MW; i++) if (mem[i] !== ref_mem[i]) nz++;
    chk({"R4 R5 memory image mismatches ", tag}, nz, 0);
    chk({"R10 store strobes ", tag}, we_total - we0, ref_st);
    chk({"R10 no read/write overlap ", tag}, overlap_total - ov0, 0);
    // R12 frozen machine
    pc_hold = dbg_pc;
    repeat (3) @(negedge clk);
    chk({"R12 pc held ", tag}, dbg_pc, pc_hold);
    chk({"R12 strobes idle ", tag}, {mem_re, mem_we}, 2'b00);
  endtask

  initial begin
    logic [15:0] v;
    void'($urandom(32'h5eed_0042));

    // directed loop: sum 10..1, stores, indirect store, imm, wrap
    for (int i = 0; i < MW; i++) img[i] = 16'h0;
    img[0]  = 16'h3000; img[1]  = 16'h310A; img[2]  = 16'h3201; img[3]  = 16'h3300;
    img[4]  = 16'h6109; img[5]  = 16'h4010; img[6]  = 16'h5120; img[7]  = 16'h6304;
    img[9]  = 16'h1090; img[10] = 16'h0491; img[11] = 16'h3592; img[12] = 16'h2540;
    img[13] = 16'h7FFF; img[14] = 16'hF123; img[15] = 16'h36FF; img[16] = 16'h5767;
    img[17] = 16'h6311; img[8'h91] = 16'hBEEF;
    run_prog(60, "directed");
    chk("R8 loop parked pc", dbg_pc, 16'd17);
    read_reg(0, v);  chk("R7 add sum", v, 16'd55);
    read_reg(4, v);  chk("R3 load direct", v, 16'hBEEF);
    read_reg(6, v);  chk("R6 imm zero-extended", v, 16'h00FF);
    read_reg(7, v);  chk("R7 sub wraps", v, 16'hFF01);
    read_reg(1, v);  chk("R7 counter reached zero", v, 16'h0);
    chk("R4 store direct", mem[8'h90], 16'd55);
    chk("R5 store indirect", mem[8'h92], 16'hBEEF);

    // unused opcodes leave state untouched
    for (int i = 0; i < MW; i++) img[i] = 16'h1111;
    img[0] = 16'h3A5A;
    for (int k = 0; k < 9; k++) img[1+k] = {4'(7 + k), 12'hA90};
    img[10] = 16'h6B0A;
    run_prog(20, "unused-opcodes");
    read_reg(10, v); chk("R9 reg kept", v, 16'h005A);
    chk("R9 pc parked", dbg_pc, 16'd10);
    chk("R9 memory untouched", mem[8'h90], 16'h1111);

    // random programs
    for (int t = 0; t < 6; t++) begin
      for (int i = 0; i < MW; i++) begin
        img[i] = 16'($urandom);
        if (i < 64 && ($urandom % 3) != 0) img[i][15:12] = 4'($urandom % 7);
      end
      run_prog(150, $sformatf("random%0d", t));
    end

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule